// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

This unit is a datapath slice that reorders the bytes of a 32-bit operand and reports four status flags for the reordered value. A 2-bit operation code picks one of three arrangements. The first swaps the two bytes inside each 16-bit half. The second reverses the order of all four bytes, which converts between big-endian and little-endian words. The third exchanges the two 16-bit halves.

The flags are zero (Z), sign (S), carry (CY) and overflow (OV). The carry flag does not report an arithmetic carry. It reports zero lanes in the result, and each arrangement has its own rule for which lanes count. Software uses this to scan packed strings for a terminating null byte or an empty halfword.

The fourth operation code is reserved. When it is selected, the operand passes through unchanged and an illegal-operation output is raised.

By default the result, flags and illegal indication are captured in one output register. When the register is enabled, an input presented before a rising clock edge appears at the outputs just after that edge. When the register is disabled, the unit is purely combinational. The unit has no other state: it does not hold the operand between operations and has no control sequence.

Top module: `swap_unit`

## Requirements
- R1: With `op_i` = 2'b00, `result_o` equals `{src[23:16], src[31:24], src[7:0], src[15:8]}`.
- R2: With `op_i` = 2'b01, `result_o` equals `{src[7:0], src[15:8], src[23:16], src[31:24]}`.
- R3: With `op_i` = 2'b10, `result_o` equals `{src[15:0], src[31:16]}`.
- R4: For op codes 2'b00, 2'b01 and 2'b10, `zero_o` is 1 exactly when all 32 bits of `result_o` are zero.
- R5: For op codes 2'b00, 2'b01 and 2'b10, `sign_o` equals `result_o[31]`.
- R6: `ovf_o` is 0 for every op code.
- R7: With `op_i` = 2'b00, `carry_o` is 1 exactly when `result_o[7:0]` is zero. Zero bytes elsewhere in the result do not set it.
- R8: With `op_i` = 2'b01, `carry_o` is 1 when any of the four bytes of `result_o` is zero.
- R9: With `op_i` = 2'b10, `carry_o` is 1 when `result_o[15:0]` or `result_o[31:16]` is zero. A zero byte inside a nonzero half does not set it.
- R10: With `op_i` = 2'b11, `result_o` equals the operand, all four flags are 0 and `illegal_o` is 1. For every other op code, `illegal_o` is 0.
- R11: With the output register enabled (the default), the inputs present at a rising edge appear at the outputs after that edge and stay there until the next edge. While `rst_n` is low, `result_o`, all flags and `illegal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| src_i | input | 32 | Operand to rearrange |
| op_i | input | 2 | Operation: 00 swap bytes in each half, 01 reverse bytes, 10 exchange halves, 11 reserved |
| result_o | output | 32 | Rearranged value |
| zero_o | output | 1 | Result is all zero |
| sign_o | output | 1 | Bit 31 of the result |
| carry_o | output | 1 | Zero-lane indication, with a rule that depends on the operation |
| ovf_o | output | 1 | Overflow flag, always 0 |
| illegal_o | output | 1 | The reserved op code was selected |

## Verification
Each operation is driven with operands whose four bytes are all distinct, so a misplaced lane shows up in the result.

Operands are also chosen so that zero bytes fall in positions that separate the three carry rules:
- a zero byte in a high position under the in-half swap must leave carry clear;
- a zero byte inside a nonzero half under the half exchange must leave carry clear;
- a single zero byte under the full reversal must set carry.

Operands with bit 31 set in the result exercise the sign flag. An all-zero operand is applied in every mode to check zero and carry together. The reserved code is tried with a nonzero operand and with zero, which shows that the zero flag stays clear on pass-through.

Directed steps confirm the one-edge latency and the cleared outputs during reset, including a reset applied in the middle of a run.

// File: rtl/swap_pkg.sv
package swap_pkg;

    // Operation codes; the encoding is visible on the op_i port.
    typedef enum logic [1:0] {
        SW_HALF_BYTES = 2'b00,
        SW_WORD_REV   = 2'b01,
        SW_HALF_EXCH  = 2'b10,
        SW_RSVD       = 2'b11
    } swap_op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic cy;
        logic ov;
    } swap_flags_t;

    localparam swap_flags_t FLAGS_CLEAR = '{z: 1'b0, s: 1'b0, cy: 1'b0, ov: 1'b0};

endpackage

// File: rtl/swap_permute.sv
module swap_permute
    import swap_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [LANE_W*LANES-1:0] src_i,
    input  swap_op_e                op_i,
    output logic [LANE_W*LANES-1:0] perm_o,
    output logic                    rsvd_o
);
    localparam int DATA_W = LANE_W * LANES;
    localparam int HALF   = LANES / 2;

    logic [DATA_W-1:0] half_bytes;
    logic [DATA_W-1:0] word_rev;
    logic [DATA_W-1:0] half_exch;

    // One lane of each candidate arrangement per generate iteration.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int PAIR = g ^ 1;
        localparam int REV  = LANES - 1 - g;
        localparam int XCH  = (g + HALF) % LANES;
        assign half_bytes[g*LANE_W +: LANE_W] = src_i[PAIR*LANE_W +: LANE_W];
        assign word_rev  [g*LANE_W +: LANE_W] = src_i[REV *LANE_W +: LANE_W];
        assign half_exch [g*LANE_W +: LANE_W] = src_i[XCH *LANE_W +: LANE_W];
    end

    always_comb begin
        perm_o = src_i;
        rsvd_o = 1'b0;
        unique case (op_i)
            SW_HALF_BYTES: perm_o = half_bytes;
            SW_WORD_REV:   perm_o = word_rev;
            SW_HALF_EXCH:  perm_o = half_exch;
            SW_RSVD: begin
                perm_o = src_i;
                rsvd_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/swap_flags.sv
module swap_flags
    import swap_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [LANE_W*LANES-1:0] perm_i,
    input  swap_op_e                op_i,
    output swap_flags_t             flags_o
);
    localparam int DATA_W = LANE_W * LANES;
    localparam int HALF_W = DATA_W / 2;

    logic [LANES-1:0] lane_zero;
    logic             lo_half_zero;
    logic             hi_half_zero;
    logic             all_zero;

    for (genvar g = 0; g < LANES; g++) begin : g_zero
        assign lane_zero[g] = (perm_i[g*LANE_W +: LANE_W] == '0);
    end

    assign lo_half_zero = (perm_i[HALF_W-1:0]      == '0);
    assign hi_half_zero = (perm_i[DATA_W-1:HALF_W] == '0);
    assign all_zero     = &lane_zero;

    always_comb begin
        flags_o = FLAGS_CLEAR;
        unique case (op_i)
            SW_HALF_BYTES: begin
                flags_o.z  = all_zero;
                flags_o.s  = perm_i[DATA_W-1];
                flags_o.cy = lane_zero[0];
            end
            SW_WORD_REV: begin
                flags_o.z  = all_zero;
                flags_o.s  = perm_i[DATA_W-1];
                flags_o.cy = |lane_zero;
            end
            SW_HALF_EXCH: begin
                flags_o.z  = all_zero;
                flags_o.s  = perm_i[DATA_W-1];
                flags_o.cy = lo_half_zero | hi_half_zero;
            end
            SW_RSVD: flags_o = FLAGS_CLEAR;
        endcase
    end

endmodule

// File: rtl/swap_unit.sv
module swap_unit
    import swap_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int LANES   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANE_W*LANES-1:0] src_i,
    input  logic [1:0]              op_i,
    output logic [LANE_W*LANES-1:0] result_o,
    output logic                    zero_o,
    output logic                    sign_o,
    output logic                    carry_o,
    output logic                    ovf_o,
    output logic                    illegal_o
);
    localparam int DATA_W = LANE_W * LANES;

    swap_op_e          op;
    logic [DATA_W-1:0] perm;
    logic              rsvd;
    swap_flags_t       flags;

    assign op = swap_op_e'(op_i);

    swap_permute #(.LANE_W(LANE_W), .LANES(LANES)) u_perm (
        .src_i (src_i),
        .op_i  (op),
        .perm_o(perm),
        .rsvd_o(rsvd)
    );

    swap_flags #(.LANE_W(LANE_W), .LANES(LANES)) u_flags (
        .perm_i (perm),
        .op_i   (op),
        .flags_o(flags)
    );

    logic [DATA_W-1:0] res_q;
    swap_flags_t       flags_q;
    logic              ill_q;

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q   <= '0;
                flags_q <= FLAGS_CLEAR;
                ill_q   <= 1'b0;
            end else begin
                res_q   <= perm;
                flags_q <= flags;
                ill_q   <= rsvd;
            end
        end
    end else begin : g_comb
        assign res_q   = perm;
        assign flags_q = flags;
        assign ill_q   = rsvd;
    end

    assign result_o  = res_q;
    assign zero_o    = flags_q.z;
    assign sign_o    = flags_q.s;
    assign carry_o   = flags_q.cy;
    assign ovf_o     = flags_q.ov;
    assign illegal_o = ill_q;

endmodule

// File: rtl/swap_unit_chk.sv
module swap_unit_chk #(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] src_i,
    input logic [1:0]        op_i,
    input logic [DATA_W-1:0] result_o,
    input logic              zero_o,
    input logic              sign_o,
    input logic              carry_o,
    input logic              ovf_o,
    input logic              illegal_o
);
    logic [DATA_W-1:0] ref_src;
    logic [1:0]        ref_op;
    logic              ref_ok;

    // Inputs that the current outputs belong to.
    if (REG_OUT) begin : g_ref_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ref_src <= '0;
                ref_op  <= 2'b00;
                ref_ok  <= 1'b0;
            end else begin
                ref_src <= src_i;
                ref_op  <= op_i;
                ref_ok  <= 1'b1;
            end
        end
    end else begin : g_ref_comb
        assign ref_src = src_i;
        assign ref_op  = op_i;
        assign ref_ok  = 1'b1;
    end

    if (DATA_W == 32) begin : g_w32
        a_r1_half_bytes: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_ok && ref_op == 2'b00) |->
            result_o == {ref_src[23:16], ref_src[31:24], ref_src[7:0], ref_src[15:8]});

        a_r2_word_rev: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_ok && ref_op == 2'b01) |->
            result_o == {ref_src[7:0], ref_src[15:8], ref_src[23:16], ref_src[31:24]});

        a_r3_half_exch: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_ok && ref_op == 2'b10) |->
            result_o == {ref_src[15:0], ref_src[31:16]});

        a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_ok && ref_op != 2'b11) |-> zero_o == (result_o == '0));

        a_r5_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_ok && ref_op != 2'b11) |-> sign_o == result_o[31]);

        a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            ref_ok |-> !ovf_o);

        a_r7_carry_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_ok && ref_op == 2'b00) |-> carry_o == (ref_src[15:8] == 8'h00));

        a_r8_carry_any_byte: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_ok && ref_op == 2'b01) |->
            carry_o == (ref_src[7:0] == 8'h00 || ref_src[15:8] == 8'h00 ||
                        ref_src[23:16] == 8'h00 || ref_src[31:24] == 8'h00));

        a_r9_carry_half: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_ok && ref_op == 2'b10) |->
            carry_o == (ref_src[15:0] == 16'h0000 || ref_src[31:16] == 16'h0000));

        a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
            ref_ok |-> (illegal_o == (ref_op == 2'b11)) &&
                       (ref_op != 2'b11 ||
                        (result_o == ref_src && !zero_o && !sign_o && !carry_o && !ovf_o)));
    end

endmodule

bind swap_unit swap_unit_chk #(.DATA_W(LANE_W*LANES), .REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .op_i     (op_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .sign_o   (sign_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o),
    .illegal_o(illegal_o)
);

// File: tb/tb_swap_unit.sv
`timescale 1ns/1ps
module tb_swap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [1:0]  op = 2'b00;
    logic [31:0] result;
    logic        z, s, cy, ov, ill;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    swap_unit dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src),
        .op_i     (op),
        .result_o (result),
        .zero_o   (z),
        .sign_o   (s),
        .carry_o  (cy),
        .ovf_o    (ov),
        .illegal_o(ill)
    );

    // Vector layout: {op[1:0], src[31:0], result[31:0], flags {z,s,cy,ov}, illegal}
    localparam int NV = 15;
    localparam logic [70:0] VEC [NV] = '{
        {2'b00, 32'h12345678, 32'h34127856, 4'b0000, 1'b0},  // R1 R7 distinct bytes
        {2'b00, 32'h00FF1200, 32'hFF000012, 4'b0100, 1'b0},  // R7 zero high byte, no carry; R5
        {2'b00, 32'h12340056, 32'h34125600, 4'b0010, 1'b0},  // R7 low byte zero
        {2'b01, 32'h12345678, 32'h78563412, 4'b0000, 1'b0},  // R2
        {2'b01, 32'h80FF10C3, 32'hC310FF80, 4'b0100, 1'b0},  // R2 R5
        {2'b01, 32'h11002233, 32'h33220011, 4'b0010, 1'b0},  // R8 one zero byte
        {2'b01, 32'h000000FF, 32'hFF000000, 4'b0110, 1'b0},  // R8 R5
        {2'b10, 32'h12345678, 32'h56781234, 4'b0000, 1'b0},  // R3
        {2'b10, 32'h0000ABCD, 32'hABCD0000, 4'b0110, 1'b0},  // R9 R5
        {2'b10, 32'h00120034, 32'h00340012, 4'b0000, 1'b0},  // R9 zero bytes, halves nonzero
        {2'b00, 32'h00000000, 32'h00000000, 4'b1010, 1'b0},  // R4
        {2'b01, 32'h00000000, 32'h00000000, 4'b1010, 1'b0},  // R4
        {2'b10, 32'h00000000, 32'h00000000, 4'b1010, 1'b0},  // R4
        {2'b11, 32'hDEADBEEF, 32'hDEADBEEF, 4'b0000, 1'b1},  // R10
        {2'b11, 32'h00000000, 32'h00000000, 4'b0000, 1'b1}   // R10 zero flag stays clear
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tags_for(input logic [1:0] o);
        case (o)
            2'b00:   return "R1 R4 R5 R6 R7";
            2'b01:   return "R2 R4 R5 R6 R8";
            2'b10:   return "R3 R4 R5 R6 R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        // Reset state with a nonzero operand applied (R11)
        src = 32'hA5A5A5A5;
        op  = 2'b01;
        repeat (3) @(negedge clk);
        check("R11 reset result", result, 32'h0);
        check("R11 reset flags", {28'h0, z, s, cy, ov}, 32'h0);
        check("R11 reset illegal", {31'h0, ill}, 32'h0);
        rst_n = 1'b1;

        // Table walk: one vector per cycle, back to back
        for (int i = 0; i < NV; i++) begin
            op  = VEC[i][70:69];
            src = VEC[i][68:37];
            @(negedge clk);
            check({tags_for(VEC[i][70:69]), " result"}, result, VEC[i][36:5]);
            check({tags_for(VEC[i][70:69]), " flags"}, {28'h0, z, s, cy, ov}, {28'h0, VEC[i][4:1]});
            check({tags_for(VEC[i][70:69]), " illegal"}, {31'h0, ill}, {31'h0, VEC[i][0]});
        end

        // Latency: outputs keep the previous result until the next edge (R11)
        op  = 2'b10;
        src = 32'hCAFE0001;
        @(negedge clk);
        check("R3 R11 exchange", result, 32'h0001CAFE);
        op  = 2'b01;
        src = 32'h01020304;
        #1;
        check("R11 hold before edge", result, 32'h0001CAFE);
        @(negedge clk);
        check("R2 R11 after edge", result, 32'h04030201);
        check("R6 R8 flags", {28'h0, z, s, cy, ov}, 32'h0);

        // Reset in the middle of a run clears outputs at once (R11)
        rst_n = 1'b0;
        #1;
        check("R11 async reset result", result, 32'h0);
        check("R11 async reset illegal", {31'h0, ill}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        op  = 2'b11;
        src = 32'h80000000;
        @(negedge clk);
        check("R10 pass sign bit", result, 32'h80000000);
        check("R10 flags clear", {28'h0, z, s, cy, ov}, 32'h0);
        check("R10 illegal", {31'h0, ill}, 32'h1);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule